// File: doc/BRIEF.md
# Bit-Serial Accumulator Processor Core

This block is a 16-bit accumulator processor that moves every datum through its datapath one bit per clock, least significant bit first. It keeps three architectural registers: an accumulator, a program counter and a flags word. Each instruction word holds a 4-bit opcode in bits 15:12 and a 12-bit operand in bits 11:0, and addresses count 16-bit words.

All traffic with memory and peripherals crosses a serial bus: one output bit, one input bit, and three enables that mark an address phase, a read phase or a write phase. Every state of the sequencer lasts exactly 16 bit-cycles. An external memory controller shifts in the address during an address phase and then either serves a word on the input bit or captures the word on the output bit. The controller state machine walks through reset, fetch, indirect, operand, execute, load, store, advance and halt states.

Opcodes, by code: 0 OR, 1 AND, 2 XOR, 3 ADD, 4 shift left, 5 shift right, 6 load, 7 store, 8 load from constant address, 9 store to constant address, 10 literal, 11 no-op, 12 jump, 13 jump if zero, 14 set register, 15 get register. Flags bits: 0 carry, 1 zero, 2 negative, 3 restart request, 4 halt request, 5 indirect enable, 6 rotate select.

Top module: `bsc_core`

## Requirements
- R1: An instruction is read over one read phase of 16 cycles, bit 0 first; opcode is bits 15:12 and operand bits 11:0.
- R2: Opcodes 0 to 3 replace the accumulator with acc OR v, acc AND v, acc XOR v, and acc + v + carry, where v is the operand value; ADD writes its carry out to flags bit 0 and the other three leave bit 0 unchanged.
- R3: Opcodes 4 and 5 move the accumulator left or right by v[3:0] places; with flags bit 6 set the bits wrap around, with it clear vacated bits fill with 0 and any v of 16 or more gives 0.
- R4: With flags bit 5 set, opcodes 0 to 7 take v from the memory word at the operand address (an address phase followed by a read phase); opcodes 8 to 15 always use the raw operand, zero-extended.
- R5: Load (6) sets acc to memory[v], store (7) writes acc to memory[v], and opcodes 8 and 9 do the same at the operand address.
- R6: Literal (10) sets acc to the zero-extended operand; opcode 11 changes no register.
- R7: Jump (12) sets the PC to the operand; jump-if-zero (13) does so only when acc is 0, otherwise the PC advances by one.
- R8: Set (14) copies acc to the flags when operand bit 0 is 1, else to the PC; get (15) loads acc from the flags when operand bit 0 is 1, else from the PC of the get instruction itself.
- R9: After every instruction that reaches the advance state, flags bit 1 equals (acc == 0) and bit 2 equals acc bit 15.
- R10: A set halt flag, found at the end of a fetch, wins over the restart flag and enters a halt state that is never left; there `halted` is 1 and all enables are 0.
- R11: A set restart flag, found at the end of a fetch, clears acc, PC and flags and resumes fetching at address 0.
- R12: Each bus phase is 16 consecutive cycles with exactly one enable high, at most one enable is ever high, `bus_out` is 0 outside address and write phases, and bits 15:12 of an address word carry flags bits 3:0.
- R13: While reset is applied all enables, `bus_out` and `halted` are 0; the first phase after reset is an address phase for address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_in | input | 1 | Serial read data, sampled in read phases |
| bus_out | output | 1 | Serial address or write data, bit 0 first |
| rd_en | output | 1 | Read phase in progress |
| wr_en | output | 1 | Write phase in progress |
| adr_en | output | 1 | Address phase in progress |
| halted | output | 1 | Core is in the halt state |

## Verification
The assertions assume that the memory side answers every read phase with a full 16-bit word timed to the core's own bit count, and that reset is only released into a core that then runs on free; they place no constraint on the data values. The bench meets this with a memory model that counts enable cycles itself, latches an address after sixteen address bits, drives read bits on the falling edge and commits a write after sixteen write bits. Every program ends by setting the halt flag, so each run reaches the halt state and the phase timing is observed from reset to halt.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_FETCH, ST_INDIR, ST_OPND, ST_EXEC,
    ST_LOAD, ST_STORE, ST_ADV, ST_HALT
  } state_e;

  typedef enum logic [3:0] {
    OPC_OR, OPC_AND, OPC_XOR, OPC_ADD, OPC_SHL, OPC_SHR, OPC_LD, OPC_ST,
    OPC_LDC, OPC_STC, OPC_LIT, OPC_NOP, OPC_JMP, OPC_JZ, OPC_SET, OPC_GET
  } opc_e;

  localparam int FL_CY  = 0;
  localparam int FL_Z   = 1;
  localparam int FL_N   = 2;
  localparam int FL_RST = 3;
  localparam int FL_HLT = 4;
  localparam int FL_IND = 5;
  localparam int FL_ROT = 6;

endpackage

// File: rtl/bsc_rst_sync.sv
module bsc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/bsc_bitcnt.sv
module bsc_bitcnt #(
  parameter int W = 16,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          last
);
  logic [CW-1:0] cnt_nx;

  assign last = (cnt == CW'(W - 1));

  always_comb begin
    if (last) cnt_nx = '0;
    else      cnt_nx = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end
endmodule

// File: rtl/bsc_alu_bit.sv
module bsc_alu_bit (
  input  logic [1:0] fn,
  input  logic       a,
  input  logic       b,
  input  logic       ci,
  output logic       r,
  output logic       co
);
  always_comb begin
    co = ci;
    case (fn)
      2'd0: r = a | b;
      2'd1: r = a & b;
      2'd2: r = a ^ b;
      default: begin
        r  = a ^ b ^ ci;
        co = (a & b) | (a & ci) | (b & ci);
      end
    endcase
  end
endmodule

// File: rtl/bsc_ctrl.sv
module bsc_ctrl
  import bsc_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           last,
  input  logic [OPW-1:0] fetch_opc,
  input  logic [OPW-1:0] opc,
  input  logic           sel_bit,
  input  logic           acc_zero,
  input  logic           fl_hlt,
  input  logic           fl_rst,
  input  logic           fl_ind,
  output state_e         state,
  output state_e         state_nx
);
  always_comb begin
    state_nx = state;
    if (last) begin
      case (state)
        ST_RESET: state_nx = ST_FETCH;
        ST_FETCH: begin
          if (fl_hlt)                          state_nx = ST_HALT;
          else if (fl_rst)                     state_nx = ST_RESET;
          else if (fl_ind && !fetch_opc[OPW-1]) state_nx = ST_INDIR;
          else                                 state_nx = ST_EXEC;
        end
        ST_INDIR: state_nx = ST_OPND;
        ST_OPND:  state_nx = ST_EXEC;
        ST_EXEC: begin
          case (opc_e'(opc))
            OPC_LD, OPC_LDC: state_nx = ST_LOAD;
            OPC_ST, OPC_STC: state_nx = ST_STORE;
            OPC_JMP:         state_nx = ST_FETCH;
            OPC_JZ:          state_nx = acc_zero ? ST_FETCH : ST_ADV;
            OPC_SET:         state_nx = sel_bit ? ST_ADV : ST_FETCH;
            default:         state_nx = ST_ADV;
          endcase
        end
        ST_LOAD:  state_nx = ST_ADV;
        ST_STORE: state_nx = ST_ADV;
        ST_ADV:   state_nx = ST_FETCH;
        default:  state_nx = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_nx;
  end
endmodule

// File: rtl/bsc_core.sv
module bsc_core
  import bsc_pkg::*;
#(
  parameter int W   = 16,
  parameter int OPW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic bus_out,
  output logic rd_en,
  output logic wr_en,
  output logic adr_en,
  output logic halted
);
  localparam int AW = W - OPW;
  localparam int CW = $clog2(W);

  logic          srst_n;
  logic [CW-1:0] cnt;
  logic          last;
  state_e        state, state_nx;

  logic [W-1:0]  acc, acc_nx;
  logic [W-1:0]  pc, pc_nx;
  logic [W-1:0]  flags, flags_nx;
  logic [W-1:0]  instr, instr_nx;
  logic [W-1:0]  lop, lop_nx;
  logic          cy, cy_nx;

  logic [OPW-1:0] opc;
  logic [AW-1:0]  opnd;
  logic [W-1:0]   op_ext, word_in, get_src, out_word, shl1, shr1;
  logic [AW-1:0]  exec_adr;
  logic           acc_zero, exec_bus, rot, big_amt;
  logic [CW-1:0]  amt;
  logic           alu_ci, alu_r, alu_co;

  bsc_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  bsc_bitcnt #(.W(W)) u_cnt (.clk(clk), .rst_n(srst_n), .cnt(cnt), .last(last));

  assign opc      = instr[W-1 -: OPW];
  assign opnd     = instr[AW-1:0];
  assign op_ext   = {{OPW{1'b0}}, opnd};
  assign word_in  = {bus_in, instr[W-1:1]};
  assign acc_zero = (acc == '0);
  assign rot      = flags[FL_ROT];
  assign amt      = lop[CW-1:0];
  assign big_amt  = |lop[W-1:CW];
  assign shl1     = {acc[W-2:0], rot & acc[W-1]};
  assign shr1     = {rot & acc[0], acc[W-1:1]};
  assign get_src  = opnd[0] ? flags : pc;
  assign alu_ci   = (cnt == '0) ? flags[FL_CY] : cy;

  bsc_ctrl #(.OPW(OPW)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .last(last),
    .fetch_opc(word_in[W-1 -: OPW]), .opc(opc), .sel_bit(opnd[0]),
    .acc_zero(acc_zero), .fl_hlt(flags[FL_HLT]), .fl_rst(flags[FL_RST]),
    .fl_ind(flags[FL_IND]), .state(state), .state_nx(state_nx)
  );

  bsc_alu_bit u_alu (
    .fn(opc[1:0]), .a(acc[0]), .b(lop[cnt]), .ci(alu_ci),
    .r(alu_r), .co(alu_co)
  );

  // Address source and bus use of the execute phase
  always_comb begin
    exec_bus = 1'b0;
    exec_adr = opnd;
    case (opc_e'(opc))
      OPC_LD, OPC_ST: begin
        exec_bus = 1'b1;
        exec_adr = lop[AW-1:0];
      end
      OPC_LDC, OPC_STC, OPC_JMP: exec_bus = 1'b1;
      OPC_JZ:  exec_bus = acc_zero;
      OPC_SET: begin
        exec_bus = !opnd[0];
        exec_adr = acc[AW-1:0];
      end
      default: exec_bus = 1'b0;
    endcase
  end

  always_comb begin
    case (state)
      ST_STORE: out_word = acc;
      ST_INDIR: out_word = {flags[OPW-1:0], opnd};
      ST_EXEC:  out_word = {flags[OPW-1:0], exec_adr};
      ST_ADV:   out_word = {flags[OPW-1:0], pc[AW-1:0]};
      default:  out_word = '0;
    endcase
  end

  assign adr_en  = srst_n & ((state == ST_RESET) | (state == ST_INDIR) |
                             (state == ST_ADV) | ((state == ST_EXEC) & exec_bus));
  assign rd_en   = srst_n & ((state == ST_FETCH) | (state == ST_OPND) | (state == ST_LOAD));
  assign wr_en   = srst_n & (state == ST_STORE);
  assign bus_out = (adr_en | wr_en) & out_word[cnt];
  assign halted  = (state == ST_HALT);

  // Next-state of the datapath registers
  always_comb begin
    acc_nx   = acc;
    pc_nx    = pc;
    flags_nx = flags;
    instr_nx = instr;
    lop_nx   = lop;
    cy_nx    = cy;
    case (state)
      ST_RESET: begin
        acc_nx   = '0;
        pc_nx    = '0;
        flags_nx = '0;
        cy_nx    = 1'b0;
      end
      ST_FETCH: begin
        instr_nx = word_in;
        if (last) lop_nx = {{OPW{1'b0}}, word_in[AW-1:0]};
      end
      ST_OPND: lop_nx = {bus_in, lop[W-1:1]};
      ST_LOAD: acc_nx = {bus_in, acc[W-1:1]};
      ST_EXEC: begin
        case (opc_e'(opc))
          OPC_OR, OPC_AND, OPC_XOR, OPC_ADD: begin
            acc_nx = {alu_r, acc[W-1:1]};
            cy_nx  = alu_co;
            if (last && (opc_e'(opc) == OPC_ADD)) flags_nx[FL_CY] = alu_co;
          end
          OPC_SHL, OPC_SHR: begin
            if (cnt < amt) acc_nx = (opc_e'(opc) == OPC_SHL) ? shl1 : shr1;
            if (last && big_amt && !rot) acc_nx = '0;
          end
          OPC_LIT: acc_nx = {op_ext[cnt], acc[W-1:1]};
          OPC_GET: acc_nx = {get_src[cnt], acc[W-1:1]};
          OPC_SET: begin
            if (last) begin
              if (opnd[0]) flags_nx = acc;
              else         pc_nx    = acc;
            end
          end
          OPC_JMP: if (last) pc_nx = op_ext;
          OPC_JZ:  if (last && acc_zero) pc_nx = op_ext;
          default: ;
        endcase
      end
      ST_ADV: begin
        if (last) begin
          flags_nx[FL_Z] = acc_zero;
          flags_nx[FL_N] = acc[W-1];
        end
      end
      default: ;
    endcase
    if (last && (state_nx == ST_ADV) && (state != ST_ADV)) pc_nx = pc + W'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      acc   <= '0;
      pc    <= '0;
      flags <= '0;
      instr <= '0;
      lop   <= '0;
      cy    <= 1'b0;
    end else begin
      acc   <= acc_nx;
      pc    <= pc_nx;
      flags <= flags_nx;
      instr <= instr_nx;
      lop   <= lop_nx;
      cy    <= cy_nx;
    end
  end
endmodule

// File: rtl/bsc_core_chk.sv
module bsc_core_chk #(
  parameter int W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic rd_en,
  input logic wr_en,
  input logic adr_en,
  input logic bus_out,
  input logic halted
);
  logic [2:0]  en, en_q;
  logic [15:0] run;

  assign en = {rd_en, wr_en, adr_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      run  <= '0;
    end else begin
      en_q <= en;
      if (en == en_q) run <= run + 16'd1;
      else            run <= 16'd1;
    end
  end

  // R12: never two enables at once
  p_one_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en));

  // R12: output bit idle outside address and write phases
  p_quiet_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(adr_en || wr_en) |-> !bus_out);

  // R12: a finished phase lasted a whole multiple of the word width
  p_phase_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((en != en_q) && (en_q != 3'b000)) |-> ((run % W) == 0));

  // R10: halt is absorbing
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R10: no bus activity while halted
  p_halt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (en == 3'b000));
endmodule

bind bsc_core bsc_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(srst_n), .rd_en(rd_en), .wr_en(wr_en),
  .adr_en(adr_en), .bus_out(bus_out), .halted(halted)
);

// File: tb/test_bsc_core.sv
module test_bsc_core;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic bus_in = 1'b0;
  logic bus_out, rd_en, wr_en, adr_en, halted;

  bsc_core i_bsc_core (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
    .rd_en(rd_en), .wr_en(wr_en), .adr_en(adr_en), .halted(halted)
  );

  logic [15:0] mem [0:255];
  int errs = 0;
  int checks = 0;
  int cyc = 0;

  // memory model state
  int abit = 0, ibit = 0, obit = 0;
  logic [15:0] abuf = '0, obuf = '0, cur_addr = '0, first_addr = '0;
  logic [3:0]  ind_hi = '0;
  logic        first_seen = 1'b0, started = 1'b0;
  int          span = 0;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 185000) begin
      errs++;
      checks++;
      $display("FAIL R10 watchdog: actual cycles=%0d expected below 185000", cyc);
      summary();
      $finish;
    end
    if (!rst_n) begin
      abit = 0; ibit = 0; obit = 0;
      first_seen = 1'b0; started = 1'b0; span = 0;
    end else begin
      if (rd_en || wr_en || adr_en) started = 1'b1;
      if (started && !halted) span++;
      if (adr_en) begin
        abuf[abit] = bus_out;
        if (abit == 15) begin
          cur_addr = abuf;
          abit = 0;
          if (!first_seen) begin
            first_addr = abuf;
            first_seen = 1'b1;
          end
          if (abuf[11:0] == 12'h091) ind_hi = abuf[15:12];
        end else abit++;
      end
      if (rd_en) begin
        bus_in = mem[cur_addr[7:0]][ibit];
        ibit = (ibit == 15) ? 0 : ibit + 1;
      end
      if (wr_en) begin
        obuf[obit] = bus_out;
        if (obit == 15) begin
          mem[cur_addr[7:0]] = obuf;
          obit = 0;
        end else obit++;
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_prog(input string tag);
    int n = 0;
    while (!halted && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " R10 reached halt"}, {15'd0, halted}, 16'h0001);
  endtask

  function automatic logic [16:0] model(input logic [3:0] opc, input logic [15:0] a,
                                       input logic [15:0] b, input logic cin, input logic rot);
    logic [31:0] t;
    logic [16:0] s;
    int amt;
    amt = int'(b[3:0]);
    case (opc)
      4'd0: return {cin, a | b};
      4'd1: return {cin, a & b};
      4'd2: return {cin, a ^ b};
      4'd3: begin
        s = {1'b0, a} + {1'b0, b} + {16'd0, cin};
        return s;
      end
      4'd4: begin
        if (!rot && b >= 16) return {cin, 16'h0000};
        if (rot) begin
          t = {a, a} << amt;
          return {cin, t[31:16]};
        end
        return {cin, a << amt};
      end
      default: begin
        if (!rot && b >= 16) return {cin, 16'h0000};
        if (rot) begin
          t = {a, a} >> amt;
          return {cin, t[15:0]};
        end
        return {cin, a >> amt};
      end
    endcase
  endfunction

  task automatic alu_case(input logic [3:0] opc, input logic [15:0] a, input logic [15:0] b,
                          input logic cin, input logic rot);
    logic [16:0] m;
    logic [15:0] ef;
    clear_mem();
    mem[0] = {4'hA, 12'h020 | {5'd0, rot, 5'd0, cin}};
    mem[1] = 16'hE001;
    mem[2] = 16'h8090;
    mem[3] = {opc, 12'h091};
    mem[4] = 16'h90A0;
    mem[5] = 16'hF001;
    mem[6] = 16'h90A1;
    mem[7] = 16'hA010;
    mem[8] = 16'hE001;
    mem[8'h90] = a;
    mem[8'h91] = b;
    do_reset();
    run_prog("alu");
    m  = model(opc, a, b, cin, rot);
    ef = {9'd0, rot, 1'b1, 2'b00, m[15], (m[15:0] == 16'h0), m[16]};
    if (opc < 4) check("R2 R4 logic/add result", mem[8'hA0], m[15:0]);
    else         check("R3 R4 shift result", mem[8'hA0], m[15:0]);
    check("R9 R2 flags after op", mem[8'hA1], ef);
    check("R12 address bits 15:12", {12'd0, ind_hi}, {12'd0, 1'b0, a[15], (a == 16'h0), cin});
  endtask

  logic [15:0] a_list [6];
  logic [15:0] b_list [6];
  logic [15:0] sa_list [2];
  logic [15:0] sb_list [6];

  initial begin
    a_list  = '{16'h0000, 16'hFFFF, 16'h8001, 16'h1234, 16'h7FFF, 16'hAAAA};
    b_list  = '{16'h0000, 16'hFFFF, 16'h0001, 16'h5555, 16'h8000, 16'h0F0F};
    sa_list = '{16'h8421, 16'hC003};
    sb_list = '{16'd0, 16'd1, 16'd5, 16'd15, 16'd16, 16'd19};

    // R13: quiet bus during reset, then address 0 first; R12 phase count
    clear_mem();
    mem[0] = 16'hA010;
    mem[1] = 16'hE001;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R13 outputs in reset", {11'd0, rd_en, wr_en, adr_en, bus_out, halted}, 16'h0000);
    rst_n = 1'b1;
    run_prog("timing");
    check("R13 first address", first_addr, 16'h0000);
    check("R12 R1 cycles from reset to halt", span[15:0], 16'd128);

    // R2, R3, R4, R9, R12 sweeps
    for (int op = 0; op < 4; op++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 6; i++)
          for (int k = 0; k < 2; k++)
            alu_case(4'(op), a_list[i], b_list[(i + k) % 6], c[0], 1'b0);
    for (int op = 4; op < 6; op++)
      for (int r = 0; r < 2; r++)
        for (int i = 0; i < 2; i++)
          for (int j = 0; j < 6; j++)
            alu_case(4'(op), sa_list[i], sb_list[j], 1'b0, r[0]);

    // R5, R4: load/store direct and through pointer
    clear_mem();
    mem[0] = 16'hA020; mem[1] = 16'hE001;
    mem[2] = 16'h6030; mem[3] = 16'h7031;
    mem[4] = 16'hA000; mem[5] = 16'hE001;
    mem[6] = 16'h6041; mem[7] = 16'h7052;
    mem[8] = 16'hA010; mem[9] = 16'hE001;
    mem[8'h30] = 16'h0040; mem[8'h31] = 16'h0050;
    mem[8'h40] = 16'hBEEF; mem[8'h41] = 16'h1357;
    do_reset();
    run_prog("memory");
    check("R4 R5 store through pointer", mem[8'h50], 16'hBEEF);
    check("R4 R5 pointer word untouched", mem[8'h31], 16'h0050);
    check("R5 direct load/store", mem[8'h52], 16'h1357);

    // R6, R7, R8: control flow
    clear_mem();
    mem[8'h00] = 16'hA000; mem[8'h01] = 16'hD005; mem[8'h02] = 16'hABAD;
    mem[8'h03] = 16'h90A2; mem[8'h04] = 16'hABAD; mem[8'h05] = 16'hF000;
    mem[8'h06] = 16'h90A2; mem[8'h07] = 16'hA003; mem[8'h08] = 16'hD020;
    mem[8'h09] = 16'hA00C; mem[8'h0A] = 16'hE000; mem[8'h0B] = 16'hABAD;
    mem[8'h0C] = 16'h90A3; mem[8'h0D] = 16'hC010; mem[8'h0E] = 16'hABAD;
    mem[8'h0F] = 16'h90A3; mem[8'h10] = 16'hA077; mem[8'h11] = 16'hBFFF;
    mem[8'h12] = 16'h90A4; mem[8'h13] = 16'hF000; mem[8'h14] = 16'h90A5;
    mem[8'h15] = 16'hA010; mem[8'h16] = 16'hE001;
    do_reset();
    run_prog("flow");
    check("R7 R8 taken jz then get pc", mem[8'hA2], 16'h0005);
    check("R7 R8 untaken jz then set pc", mem[8'hA3], 16'h000C);
    check("R6 literal then no-op", mem[8'hA4], 16'h0077);
    check("R7 R8 pc after jump", mem[8'hA5], 16'h0013);

    // R11: restart flag reruns from address 0
    clear_mem();
    mem[0] = 16'h80B0; mem[1] = 16'h3001; mem[2] = 16'h90B0;
    mem[3] = 16'h2002; mem[4] = 16'hD007; mem[5] = 16'hA008;
    mem[6] = 16'hE001; mem[7] = 16'hA010; mem[8] = 16'hE001;
    do_reset();
    run_prog("restart");
    check("R11 pass count after restart", mem[8'hB0], 16'h0002);

    // R10: halt wins over restart, stays halted and idle
    clear_mem();
    mem[0] = 16'h80B1; mem[1] = 16'h3001; mem[2] = 16'h90B1;
    mem[3] = 16'hA018; mem[4] = 16'hE001;
    do_reset();
    run_prog("priority");
    check("R10 single pass with both flags", mem[8'hB1], 16'h0001);
    begin
      int act = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (rd_en || wr_en || adr_en || !halted) act++;
      end
      check("R10 idle while halted", act[15:0], 16'h0000);
    end

    summary();
    $finish;
  end
endmodule